// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between the store pipeline and a single cache write port. Committed stores are parked here, one aligned 32-byte block per slot. A slot carries a byte mask, so partial stores can be collected in it. While the cache port is busy, the slots are held. They are handed to the port one at a time, oldest first, each time the port grants a transfer.

A store to a block that already has a live slot folds its enabled bytes into that slot. It does not use a second slot. A store that can neither fold into a slot nor find a free slot is refused in the same cycle with a replay flag, and the store pipeline must retry it.

Loads probe the buffer with a block tag. One cycle later they get a hit flag, the byte mask of the matching slot and that slot's bytes. Any byte outside the mask must come from the cache.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: `full`, `dr_valid`, `ld_hit` and `st_replay` are low.
- R2: A store (`st_valid`) whose tag matches no mergeable slot, while fewer than ENTRIES slots are occupied, takes a new slot. The slot holds the store's byte enables and, in each enabled byte lane (lane b = data bits 8b+7..8b), the store data. Every other byte lane holds zero.
- R3: A store whose tag matches an occupied slot that is not draining in that cycle folds into that slot. The mask becomes the OR of the old mask and `st_be`, enabled lanes take the new data, and the other lanes keep their bytes. No new slot is used.
- R4: `dr_valid` is high exactly when at least one slot is occupied. `dr_tag`, `dr_be` and `dr_data` show the oldest slot, in order of allocation. When `dr_valid` and `dr_grant` are both high at a clock edge, that slot is removed.
- R5: A store whose tag matches the slot being drained in the same cycle does not fold into it. If a slot is free, it takes a new slot.
- R6: `full` is high exactly when all ENTRIES slots are occupied. A store that cannot fold into a slot while `full` is high raises `st_replay` in the same cycle and leaves every slot unchanged.
- R7: A load probe (`ld_valid`, `ld_tag`) is answered on the next cycle from the slot contents as they were before that cycle's store and drain. A hit gives `ld_hit`=1, `ld_mask` = the slot's mask and `ld_data` = the slot's bytes. A miss, or no probe, gives all three as zero.
- R8: A slot being drained in the cycle of a probe still answers that probe.
- R9: `st_replay` is low in any cycle where `st_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_tag | input | ADDR_W-log2(BLK_BYTES) | Block address of the store |
| st_be | input | BLK_BYTES | Byte enables of the store |
| st_data | input | 8*BLK_BYTES | Store data, one byte per lane |
| st_replay | output | 1 | Store refused, must be retried |
| full | output | 1 | All slots occupied |
| dr_valid | output | 1 | Oldest slot offered to the cache port |
| dr_tag | output | ADDR_W-log2(BLK_BYTES) | Block address of the offered slot |
| dr_be | output | BLK_BYTES | Byte mask of the offered slot |
| dr_data | output | 8*BLK_BYTES | Data of the offered slot |
| dr_grant | input | 1 | Cache port accepts the offered slot |
| ld_valid | input | 1 | Load probe |
| ld_tag | input | ADDR_W-log2(BLK_BYTES) | Block address of the probe |
| ld_hit | output | 1 | Probe matched a slot (one cycle later) |
| ld_mask | output | BLK_BYTES | Lanes supplied by the buffer |
| ld_data | output | 8*BLK_BYTES | Buffered bytes, zero outside the mask |

## Verification
The bench aims at stores that hit the slot leaving in the same cycle. A design that merged into that slot would lose those bytes, and the next offered mask would show it. It runs long stretches with few grants so that the buffer fills. A design that grew past six slots, or still took a store when it should have replayed, would then offer an extra or changed block. Loads that probe the slot being drained must still hit; a design that hid that slot would report a miss and the load would read stale cache data. Because only a few block tags are used, merges happen often, and a wrong lane or a wrong mask OR shows up on the next drain.

// File: rtl/wb_pkg.sv
package wb_pkg;
  // Outcome of the store port in one cycle
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MERGE  = 2'd1,
    ST_ALLOC  = 2'd2,
    ST_REPLAY = 2'd3
  } st_act_e;

  function automatic int unsigned ring_inc(input int unsigned p, input int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/wb_match.sv
module wb_match #(
  parameter int N     = 6,
  parameter int TAG_W = 27
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = vld[i] && (tags[i] == key);
  end
endmodule

// File: rtl/wb_load_port.sv
module wb_load_port #(
  parameter int N      = 6,
  parameter int TAG_W  = 27,
  parameter int BYTES  = 32,
  localparam int DATA_W = BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  input  logic [TAG_W-1:0]        ld_tag,
  input  logic [N-1:0]            ent_v,
  input  logic [N-1:0][TAG_W-1:0] ent_tag,
  input  logic [N-1:0][BYTES-1:0] ent_be,
  input  logic [N-1:0][DATA_W-1:0] ent_data,
  output logic                    ld_hit,
  output logic [BYTES-1:0]        ld_mask,
  output logic [DATA_W-1:0]       ld_data
);
  logic [N-1:0]      hits;
  logic [BYTES-1:0]  sel_mask;
  logic [DATA_W-1:0] sel_data;

  wb_match #(.N(N), .TAG_W(TAG_W)) u_ld_match (
    .vld (ent_v),
    .tags(ent_tag),
    .key (ld_tag),
    .hit (hits)
  );

  // Tags are unique among live slots, so an OR of the selected slots is a mux
  always_comb begin
    sel_mask = '0;
    sel_data = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        sel_mask = sel_mask | ent_be[i];
        sel_data = sel_data | ent_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit  <= 1'b0;
      ld_mask <= '0;
      ld_data <= '0;
    end else begin
      ld_hit  <= ld_valid && (|hits);
      ld_mask <= ld_valid ? sel_mask : '0;
      ld_data <= ld_valid ? sel_data : '0;
    end
  end

  // R7
  ld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!ld_hit && ld_mask == '0));
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf #(
  parameter int ENTRIES   = 6,
  parameter int BLK_BYTES = 32,
  parameter int ADDR_W    = 32,
  localparam int OFS_W  = $clog2(BLK_BYTES),
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int DATA_W = BLK_BYTES * 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [BLK_BYTES-1:0] st_be,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_replay,
  output logic              full,
  output logic              dr_valid,
  output logic [TAG_W-1:0]  dr_tag,
  output logic [BLK_BYTES-1:0] dr_be,
  output logic [DATA_W-1:0] dr_data,
  input  logic              dr_grant,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  output logic              ld_hit,
  output logic [BLK_BYTES-1:0] ld_mask,
  output logic [DATA_W-1:0] ld_data
);
  import wb_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRIES);

  // Slot storage
  logic [ENTRIES-1:0]                ent_v;
  logic [ENTRIES-1:0][TAG_W-1:0]     ent_tag;
  logic [ENTRIES-1:0][BLK_BYTES-1:0] ent_be;
  logic [ENTRIES-1:0][DATA_W-1:0]    ent_data;

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  logic [ENTRIES-1:0] st_hits, head_vec, merge_vec;
  logic               draining;
  st_act_e            act;

  // Store lookup
  wb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_st_match (
    .vld (ent_v),
    .tags(ent_tag),
    .key (st_tag),
    .hit (st_hits)
  );

  assign dr_valid = (count != '0);
  assign full     = (count == CNT_MAX);
  assign draining = dr_valid && dr_grant;

  always_comb begin
    head_vec = '0;
    head_vec[head] = draining;
  end

  // The leaving slot takes no more bytes
  assign merge_vec = st_hits & ~head_vec;

  always_comb begin
    if (!st_valid)        act = ST_IDLE;
    else if (|merge_vec)  act = ST_MERGE;
    else if (!full)       act = ST_ALLOC;
    else                  act = ST_REPLAY;
  end

  assign st_replay = (act == ST_REPLAY);

  // Head slot offered to the cache port
  assign dr_tag  = ent_tag[head];
  assign dr_be   = ent_be[head];
  assign dr_data = ent_data[head];

  // Lane-wise write values for allocation and merge
  logic [DATA_W-1:0] alloc_data;
  logic [ENTRIES-1:0][DATA_W-1:0] merged_data;

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_lane
    assign alloc_data[b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8] : 8'h00;
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign merged_data[e][b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8]
                                                 : ent_data[e][b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v    <= '0;
      ent_tag  <= '0;
      ent_be   <= '0;
      ent_data <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (draining && head == IDX_W'(i)) ent_v[i] <= 1'b0;
        if (act == ST_ALLOC && tail == IDX_W'(i)) begin
          ent_v[i]    <= 1'b1;
          ent_tag[i]  <= st_tag;
          ent_be[i]   <= st_be;
          ent_data[i] <= alloc_data;
        end else if (act == ST_MERGE && merge_vec[i]) begin
          ent_be[i]   <= ent_be[i] | st_be;
          ent_data[i] <= merged_data[i];
        end
      end
    end
  end

  // Ring pointers and occupancy
  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (draining) head <= IDX_W'(ring_inc(int'(head), ENTRIES));
      if (act == ST_ALLOC) tail <= IDX_W'(ring_inc(int'(tail), ENTRIES));
      count <= count + CNT_W'(act == ST_ALLOC) - CNT_W'(draining);
    end
  end

  wb_load_port #(.N(ENTRIES), .TAG_W(TAG_W), .BYTES(BLK_BYTES)) u_ld (
    .clk     (clk),
    .rst     (rst),
    .ld_valid(ld_valid),
    .ld_tag  (ld_tag),
    .ent_v   (ent_v),
    .ent_tag (ent_tag),
    .ent_be  (ent_be),
    .ent_data(ent_data),
    .ld_hit  (ld_hit),
    .ld_mask (ld_mask),
    .ld_data (ld_data)
  );

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX);
  // R6
  replay_full_chk: assert property (@(posedge clk) disable iff (rst)
    st_replay |-> full);
  // R9
  replay_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !st_valid |-> !st_replay);
  // R3
  tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_hits));
  // R4
  drain_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (draining && !st_valid) |=> (count == $past(count) - CNT_W'(1)));
  // R4
  occ_valid_chk: assert property (@(posedge clk) disable iff (rst)
    dr_valid |-> ent_v[head]);
endmodule

// File: tb/coalesce_wbuf_tb.sv
`timescale 1ns/1ps
module coalesce_wbuf_tb_top;
  localparam int NE = 6;
  localparam int TW = 27;
  localparam int NB = 32;
  localparam int DW = 256;

  logic clk = 1'b0;
  logic rst;
  logic st_valid, st_replay, full, dr_valid, dr_grant, ld_valid, ld_hit;
  logic [TW-1:0] st_tag, dr_tag, ld_tag;
  logic [NB-1:0] st_be, dr_be, ld_mask;
  logic [DW-1:0] st_data, dr_data, ld_data;

  always #2.5 clk = ~clk;

  coalesce_wbuf dut_i (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_tag(st_tag), .st_be(st_be), .st_data(st_data),
    .st_replay(st_replay), .full(full),
    .dr_valid(dr_valid), .dr_tag(dr_tag), .dr_be(dr_be), .dr_data(dr_data),
    .dr_grant(dr_grant),
    .ld_valid(ld_valid), .ld_tag(ld_tag),
    .ld_hit(ld_hit), .ld_mask(ld_mask), .ld_data(ld_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model: queue of slots, oldest first
  logic [TW-1:0] q_tag[$];
  logic [NB-1:0] q_be[$];
  logic [DW-1:0] q_data[$];

  logic          e_hit  = 1'b0;
  logic [NB-1:0] e_mask = '0;
  logic [DW-1:0] e_data = '0;
  string         e_lbl  = "R7";
  string         dr_lbl = "R2 R3";

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old, input logic [NB-1:0] be,
                                             input logic [DW-1:0] nw);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic cyc(input logic sv, input logic [TW-1:0] stg, input logic [NB-1:0] sbe,
                     input logic [DW-1:0] sd, input logic gr, input logic lv,
                     input logic [TW-1:0] ltg);
    int n;
    int midx;
    bit drn;
    @(negedge clk);
    st_valid = sv; st_tag = stg; st_be = sbe; st_data = sd;
    dr_grant = gr; ld_valid = lv; ld_tag = ltg;
    #1;
    // response to the previous cycle's probe
    chk(e_lbl, DW'(ld_hit), DW'(e_hit));
    chk(e_lbl, DW'(ld_mask), DW'(e_mask));
    chk(e_lbl, ld_data, e_data);
    n = q_tag.size();
    chk("R6", DW'(full), DW'(n == NE));
    chk("R4", DW'(dr_valid), DW'(n != 0));
    if (n > 0) begin
      chk("R4", DW'(dr_tag), DW'(q_tag[0]));
      chk(dr_lbl, DW'(dr_be), DW'(q_be[0]));
      chk(dr_lbl, dr_data, q_data[0]);
    end
    drn = (n > 0) && gr;
    midx = -1;
    for (int i = 0; i < n; i++)
      if (q_tag[i] == stg && !(i == 0 && drn)) midx = i;
    chk(sv ? "R6" : "R9", DW'(st_replay), DW'(sv && midx < 0 && n == NE));
    // expected probe answer, from state before this cycle's updates
    e_hit = 1'b0; e_mask = '0; e_data = '0; e_lbl = "R7";
    if (lv) begin
      for (int i = 0; i < n; i++) begin
        if (q_tag[i] == ltg) begin
          e_hit = 1'b1; e_mask = q_be[i]; e_data = q_data[i];
          if (i == 0 && drn) e_lbl = "R8";
        end
      end
    end
    // model update
    if (sv) begin
      if (midx >= 0) begin
        q_be[midx]   = q_be[midx] | sbe;
        q_data[midx] = lane_mix(q_data[midx], sbe, sd);
      end else if (n < NE) begin
        q_tag.push_back(stg);
        q_be.push_back(sbe);
        q_data.push_back(lane_mix('0, sbe, sd));
      end
    end
    if (drn) begin
      void'(q_tag.pop_front());
      void'(q_be.pop_front());
      void'(q_data.pop_front());
    end
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] d;
    for (int k = 0; k < 8; k++) d[k*32 +: 32] = $urandom;
    return d;
  endfunction

  function automatic logic [NB-1:0] rnd_be();
    int s = $urandom_range(0, 3);
    if (s == 0) return '1;
    if (s == 1) return NB'(1) << $urandom_range(0, NB - 1);
    return $urandom;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    st_valid = 0; st_tag = '0; st_be = '0; st_data = '0;
    dr_grant = 0; ld_valid = 0; ld_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", DW'(full), '0);
    chk("R1", DW'(dr_valid), '0);
    chk("R1", DW'(ld_hit), '0);
    chk("R1", DW'(st_replay), '0);
    rst = 1'b0;

    // Directed: allocate, merge (R3), then store into the leaving slot (R5)
    cyc(1, 27'd5, 32'h0000_000F, rnd_data(), 0, 0, '0);
    cyc(1, 27'd5, 32'h0000_00F0, rnd_data(), 0, 1, 27'd5);
    cyc(1, 27'd5, 32'h0000_0F00, rnd_data(), 1, 1, 27'd5);   // R8 probe on draining slot
    dr_lbl = "R5";
    cyc(0, '0, '0, '0, 0, 1, 27'd5);
    cyc(0, '0, '0, '0, 1, 0, '0);
    dr_lbl = "R2 R3";

    // Directed: fill all slots, then a refused store (R6)
    for (int i = 0; i < NE; i++) cyc(1, TW'(20 + i), rnd_be(), rnd_data(), 0, 0, '0);
    cyc(1, 27'd99, '1, rnd_data(), 0, 1, 27'd99);
    cyc(1, 27'd21, '1, rnd_data(), 0, 1, 27'd21);             // merge while full
    for (int i = 0; i < NE + 2; i++) cyc(0, '0, '0, '0, 1, 1, TW'(20 + i));

    // Random phases with differing grant rates over a small tag set
    for (int i = 0; i < 4000; i++) begin
      int pct;
      case (i / 1000)
        0: pct = 10;
        1: pct = 50;
        2: pct = 90;
        default: pct = 30;
      endcase
      cyc($urandom_range(0, 3) != 0, TW'($urandom_range(0, 7)), rnd_be(), rnd_data(),
          $urandom_range(0, 99) < pct, $urandom_range(0, 1) == 1,
          TW'($urandom_range(0, 8)));
    end
    for (int i = 0; i < NE + 2; i++) cyc(0, '0, '0, '0, 1, 0, '0);
    cyc(0, '0, '0, '0, 0, 0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule